// File: doc/BRIEF.md
# Dual-Output PWM Event Action Stage with Continuous Override

This block decides the level of two pulse-width outputs, A and B, from the events reported by a time-base counter: the counter reaching zero, the counter reaching its period, and the counter matching compare A or compare B while it counts up. Each output has its own action word. In that word, each event selects one 2-bit action: leave the output alone, drive it low, drive it high, or invert it. The time base supplies a tick enable, and the outputs move only on ticks.

Software can hold either output at a fixed level with a continuous override. The override value is written to a holding (shadow) copy. That copy moves into the active copy on a selectable reload condition: counter zero, counter period, either of the two, or the next tick. Software sets the polarity of a waveform through the action words. A normal word raises the output at zero and period and lowers it at the compare match. An inverted word does the opposite.

Top module: `pwm_aq_top`

## Requirements
- R1: After reset both outputs are low, the action words are zero and the active override is "no override". Each event action then applies unmodified.
- R2: The outputs and the active override change only in a cycle where `tick` is high. Events presented without `tick` have no effect.
- R3: An action code of 0 leaves the output unchanged. Code 1 drives it low, code 2 drives it high, and code 3 inverts the level the output held before the tick.
- R4: In an action word the zero event uses bits [1:0], the period event bits [3:2], the compare-A-up event bits [5:4] and the compare-B-up event bits [9:8]. All other bits are ignored.
- R5: When several events arrive on one tick, the highest-ranked event with a non-zero action decides. The ranking is compare A, then compare B, then period, then zero.
- R6: Writing one output's action word has no effect on the other output.
- R7: Override fields sit at bits [1:0] for output A and bits [3:2] for output B. Code 0 means no override, 1 holds the output low, 2 holds it high, and 3 acts as no override. While an override is active, it sets the output on every tick regardless of events.
- R8: A write to the override shadow has no effect on the outputs until a reload. The reload mode sits at bits [7:6] of its own register: 0 reloads on a zero event, 1 on a period event, 2 on either, and 3 on any tick. The reloaded value governs the output in that same tick.
- R9: Normal polarity word 0x01A makes output A high at zero or period and low at compare A. Inverted word 0x205 makes output B low at zero or period and high at compare B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base tick enable |
| ev_zero | input | 1 | Counter reached zero |
| ev_prd | input | 1 | Counter reached period |
| ev_cmpa_up | input | 1 | Compare A match while counting up |
| ev_cmpb_up | input | 1 | Compare B match while counting up |
| act_a_we | input | 1 | Write strobe, action word of output A |
| act_a_wdata | input | ACT_W | Action word of output A |
| act_b_we | input | 1 | Write strobe, action word of output B |
| act_b_wdata | input | ACT_W | Action word of output B |
| frc_we | input | 1 | Write strobe, override shadow |
| frc_wdata | input | CTRL_W | Override shadow value |
| rld_we | input | 1 | Write strobe, reload mode register |
| rld_wdata | input | CTRL_W | Reload mode register value |
| pwm_a | output | 1 | Output A level |
| pwm_b | output | 1 | Output B level |

## Verification
The bench builds the block with its defaults: a 16-bit action word (ACT_W=16) and 8-bit control words (CTRL_W=8). With this width, action-word bits [7:6] and [15:10] exist. Setting them shows that they are ignored, and both override fields and the reload field at [7:6] can be reached. Directed tests cover every reload mode, each action code, and simultaneous event combinations for priority.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_TOGGLE = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    FRC_OFF  = 2'd0,
    FRC_LOW  = 2'd1,
    FRC_HIGH = 2'd2,
    FRC_RSVD = 2'd3
  } frc_e;

  typedef enum logic [1:0] {
    RLD_ZERO = 2'd0,
    RLD_PRD  = 2'd1,
    RLD_BOTH = 2'd2,
    RLD_NOW  = 2'd3
  } rld_e;

  typedef struct packed {
    logic zero;
    logic prd;
    logic cmpa;
    logic cmpb;
  } evt_t;

  // field positions inside the action word
  localparam int unsigned POS_ZERO = 0;
  localparam int unsigned POS_PRD  = 2;
  localparam int unsigned POS_CMPA = 4;
  localparam int unsigned POS_CMPB = 8;
  // field positions inside the override and reload words
  localparam int unsigned POS_FA   = 0;
  localparam int unsigned POS_FB   = 2;
  localparam int unsigned POS_RLD  = 6;
  localparam int unsigned NUM_CH   = 2;

  function automatic logic apply_act(input act_e a, input logic cur);
    logic r;
    case (a)
      ACT_LOW:    r = 1'b0;
      ACT_HIGH:   r = 1'b1;
      ACT_TOGGLE: r = ~cur;
      default:    r = cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/aq_resolver.sv
module aq_resolver
  import pwm_aq_pkg::*;
#(
  parameter int unsigned ACT_W = 16
) (
  input  evt_t             ev,
  input  logic [ACT_W-1:0] word,
  output act_e             sel
);
  localparam int unsigned HI_USED = POS_CMPB + 2;

  act_e f_zero, f_prd, f_cmpa, f_cmpb;
  logic unused_word;

  assign f_zero = act_e'(word[POS_ZERO +: 2]);
  assign f_prd  = act_e'(word[POS_PRD  +: 2]);
  assign f_cmpa = act_e'(word[POS_CMPA +: 2]);
  assign f_cmpb = act_e'(word[POS_CMPB +: 2]);
  assign unused_word = ^{word[ACT_W-1:HI_USED], word[POS_CMPA+3:POS_CMPA+2]};

  // lowest rank first; later hits override earlier ones
  always_comb begin
    sel = ACT_NONE;
    if (ev.zero && (f_zero != ACT_NONE)) sel = f_zero;
    if (ev.prd  && (f_prd  != ACT_NONE)) sel = f_prd;
    if (ev.cmpb && (f_cmpb != ACT_NONE)) sel = f_cmpb;
    if (ev.cmpa && (f_cmpa != ACT_NONE)) sel = f_cmpa;
  end
endmodule

// File: rtl/aq_chan.sv
module aq_chan
  import pwm_aq_pkg::*;
#(
  parameter int unsigned ACT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  evt_t             ev,
  input  logic             act_we,
  input  logic [ACT_W-1:0] act_wdata,
  input  frc_e             frc,
  output logic             lvl
);
  logic [ACT_W-1:0] word_q;
  act_e             sel;
  logic             lvl_d;

  aq_resolver #(.ACT_W(ACT_W)) u_res (
    .ev   (ev),
    .word (word_q),
    .sel  (sel)
  );

  always_comb begin
    case (frc)
      FRC_LOW:  lvl_d = 1'b0;
      FRC_HIGH: lvl_d = 1'b1;
      default:  lvl_d = apply_act(sel, lvl);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      lvl    <= 1'b0;
    end else begin
      if (act_we) word_q <= act_wdata;
      if (tick)   lvl    <= lvl_d;
    end
  end
endmodule

// File: rtl/aq_force_ctl.sv
module aq_force_ctl
  import pwm_aq_pkg::*;
#(
  parameter int unsigned CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  evt_t              ev,
  input  logic              frc_we,
  input  logic [CTRL_W-1:0] frc_wdata,
  input  logic              rld_we,
  input  logic [CTRL_W-1:0] rld_wdata,
  output frc_e              eff_a,
  output frc_e              eff_b,
  output logic [3:0]        act_q,
  output logic [3:0]        shd_q,
  output rld_e              mode_q
);
  logic       hit;
  logic       reload;
  logic [3:0] eff;
  logic       unused_bits;

  assign unused_bits = ^{frc_wdata[CTRL_W-1:4], rld_wdata[CTRL_W-1:POS_RLD+2],
                         rld_wdata[POS_RLD-1:0]};

  always_comb begin
    case (mode_q)
      RLD_ZERO: hit = ev.zero;
      RLD_PRD:  hit = ev.prd;
      RLD_BOTH: hit = ev.zero | ev.prd;
      default:  hit = 1'b1;
    endcase
  end

  assign reload = tick & hit;
  assign eff    = reload ? shd_q : act_q;
  assign eff_a  = frc_e'(eff[POS_FA +: 2]);
  assign eff_b  = frc_e'(eff[POS_FB +: 2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q  <= '0;
      act_q  <= '0;
      mode_q <= RLD_ZERO;
    end else begin
      if (frc_we) shd_q  <= frc_wdata[3:0];
      if (rld_we) mode_q <= rld_e'(rld_wdata[POS_RLD +: 2]);
      if (reload) act_q  <= shd_q;
    end
  end
endmodule

// File: rtl/pwm_aq_top.sv
module pwm_aq_top
  import pwm_aq_pkg::*;
#(
  parameter int unsigned ACT_W  = 16,
  parameter int unsigned CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ev_zero,
  input  logic              ev_prd,
  input  logic              ev_cmpa_up,
  input  logic              ev_cmpb_up,
  input  logic              act_a_we,
  input  logic [ACT_W-1:0]  act_a_wdata,
  input  logic              act_b_we,
  input  logic [ACT_W-1:0]  act_b_wdata,
  input  logic              frc_we,
  input  logic [CTRL_W-1:0] frc_wdata,
  input  logic              rld_we,
  input  logic [CTRL_W-1:0] rld_wdata,
  output logic              pwm_a,
  output logic              pwm_b
);
  evt_t             ev;
  frc_e             eff_a, eff_b;
  logic [3:0]       frc_act, frc_shd;
  rld_e             rld_mode;
  logic             ch_we    [NUM_CH];
  logic [ACT_W-1:0] ch_wdata [NUM_CH];
  frc_e             ch_frc   [NUM_CH];
  logic             ch_lvl   [NUM_CH];

  assign ev = '{zero: ev_zero, prd: ev_prd, cmpa: ev_cmpa_up, cmpb: ev_cmpb_up};

  aq_force_ctl #(.CTRL_W(CTRL_W)) u_frc (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .ev        (ev),
    .frc_we    (frc_we),
    .frc_wdata (frc_wdata),
    .rld_we    (rld_we),
    .rld_wdata (rld_wdata),
    .eff_a     (eff_a),
    .eff_b     (eff_b),
    .act_q     (frc_act),
    .shd_q     (frc_shd),
    .mode_q    (rld_mode)
  );

  assign ch_we[0]    = act_a_we;
  assign ch_we[1]    = act_b_we;
  assign ch_wdata[0] = act_a_wdata;
  assign ch_wdata[1] = act_b_wdata;
  assign ch_frc[0]   = eff_a;
  assign ch_frc[1]   = eff_b;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    aq_chan #(.ACT_W(ACT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .ev        (ev),
      .act_we    (ch_we[c]),
      .act_wdata (ch_wdata[c]),
      .frc       (ch_frc[c]),
      .lvl       (ch_lvl[c])
    );
  end

  assign pwm_a = ch_lvl[0];
  assign pwm_b = ch_lvl[1];
endmodule

// File: rtl/aq_checker.sv
module aq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       out_a,
  input logic       out_b,
  input logic [1:0] eff_a,
  input logic [1:0] eff_b,
  input logic [3:0] frc_act,
  input logic [3:0] frc_shd,
  input logic [1:0] rld_mode
);
  // R2: no tick, no output movement
  a_r2_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(out_a) && $stable(out_b)));

  // R2: active override moves only on ticks
  a_r2_hold_override: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(frc_act));

  // R7: override low on A wins over events
  a_r7_force_low_a: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && eff_a == 2'd1) |=> !out_a);

  // R7: override high on B wins over events
  a_r7_force_high_b: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && eff_b == 2'd2) |=> out_b);

  // R8: reload-on-tick mode copies the shadow at each tick
  a_r8_reload_now: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rld_mode == 2'd3) |=> (frc_act == $past(frc_shd)));
endmodule

bind pwm_aq_top aq_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .out_a    (pwm_a),
  .out_b    (pwm_b),
  .eff_a    (eff_a),
  .eff_b    (eff_b),
  .frc_act  (frc_act),
  .frc_shd  (frc_shd),
  .rld_mode (rld_mode)
);

// File: tb/sim_pwm_aq_top.sv
`timescale 1ns/1ps
module sim_pwm_aq_top;
  localparam int unsigned ACT_W  = 16;
  localparam int unsigned CTRL_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, ev_zero = 1'b0, ev_prd = 1'b0, ev_cmpa_up = 1'b0, ev_cmpb_up = 1'b0;
  logic act_a_we = 1'b0, act_b_we = 1'b0, frc_we = 1'b0, rld_we = 1'b0;
  logic [ACT_W-1:0]  act_a_wdata = '0, act_b_wdata = '0;
  logic [CTRL_W-1:0] frc_wdata = '0, rld_wdata = '0;
  logic pwm_a, pwm_b;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pwm_aq_top #(.ACT_W(ACT_W), .CTRL_W(CTRL_W)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .ev_zero(ev_zero), .ev_prd(ev_prd), .ev_cmpa_up(ev_cmpa_up), .ev_cmpb_up(ev_cmpb_up),
    .act_a_we(act_a_we), .act_a_wdata(act_a_wdata),
    .act_b_we(act_b_we), .act_b_wdata(act_b_wdata),
    .frc_we(frc_we), .frc_wdata(frc_wdata),
    .rld_we(rld_we), .rld_wdata(rld_wdata),
    .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  task automatic chk(input string req, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0b exp=%0b", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input logic t, input logic z, input logic p, input logic a, input logic b);
    @(negedge clk);
    tick = t; ev_zero = z; ev_prd = p; ev_cmpa_up = a; ev_cmpb_up = b;
    @(posedge clk);
    #1;
    tick = 1'b0; ev_zero = 1'b0; ev_prd = 1'b0; ev_cmpa_up = 1'b0; ev_cmpb_up = 1'b0;
  endtask

  task automatic wr_act(input int ch, input logic [ACT_W-1:0] d);
    @(negedge clk);
    if (ch == 0) begin act_a_we = 1'b1; act_a_wdata = d; end
    else         begin act_b_we = 1'b1; act_b_wdata = d; end
    @(posedge clk);
    #1;
    act_a_we = 1'b0; act_b_we = 1'b0;
  endtask

  task automatic wr_frc(input logic [CTRL_W-1:0] d);
    @(negedge clk);
    frc_we = 1'b1; frc_wdata = d;
    @(posedge clk);
    #1;
    frc_we = 1'b0;
  endtask

  task automatic wr_rld(input logic [1:0] m);
    @(negedge clk);
    rld_we = 1'b1; rld_wdata = {m, 6'b0};
    @(posedge clk);
    #1;
    rld_we = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R1 reset pwm_a", pwm_a, 1'b0);
    chk("R1 reset pwm_b", pwm_b, 1'b0);
    wr_act(0, 16'h0002);
    step(1, 1, 0, 0, 0);
    chk("R1 no override after reset", pwm_a, 1'b1);
  endtask

  task automatic t_tick_gate();
    do_reset();
    wr_act(0, 16'h0002);
    step(0, 1, 1, 1, 1);
    chk("R2 events without tick", pwm_a, 1'b0);
    step(1, 1, 0, 0, 0);
    chk("R2 event with tick", pwm_a, 1'b1);
  endtask

  task automatic t_codes();
    do_reset();
    wr_act(0, 16'h0002);
    step(1, 1, 0, 0, 0);
    chk("R3 code 2 high", pwm_a, 1'b1);
    wr_act(0, 16'h0000);
    step(1, 1, 0, 0, 0);
    chk("R3 code 0 hold", pwm_a, 1'b1);
    wr_act(0, 16'h0001);
    step(1, 1, 0, 0, 0);
    chk("R3 code 1 low", pwm_a, 1'b0);
    wr_act(0, 16'h0003);
    step(1, 1, 0, 0, 0);
    chk("R3 toggle from low", pwm_a, 1'b1);
    step(1, 1, 0, 0, 0);
    chk("R3 toggle from high", pwm_a, 1'b0);
  endtask

  task automatic t_fields();
    do_reset();
    // zero=low, period=high, cmpA=toggle, cmpB=low
    wr_act(0, 16'h0139);
    step(1, 0, 1, 0, 0);
    chk("R4 period field [3:2]", pwm_a, 1'b1);
    step(1, 1, 0, 0, 0);
    chk("R4 zero field [1:0]", pwm_a, 1'b0);
    step(1, 0, 0, 1, 0);
    chk("R4 compare A field [5:4]", pwm_a, 1'b1);
    step(1, 0, 0, 0, 1);
    chk("R4 compare B field [9:8]", pwm_a, 1'b0);
    wr_act(0, 16'hFCC0);
    step(1, 1, 1, 1, 1);
    chk("R4 bits outside fields ignored", pwm_a, 1'b0);
  endtask

  task automatic t_prio();
    do_reset();
    // zero=high, period=low, cmpA=high, cmpB=low
    wr_act(0, 16'h0126);
    step(1, 1, 1, 1, 1);
    chk("R5 compare A outranks all", pwm_a, 1'b1);
    step(1, 1, 1, 0, 0);
    chk("R5 period outranks zero", pwm_a, 1'b0);
    step(1, 1, 0, 0, 0);
    chk("R5 zero alone", pwm_a, 1'b1);
    step(1, 1, 0, 0, 1);
    chk("R5 compare B outranks zero", pwm_a, 1'b0);
    step(1, 0, 0, 1, 1);
    chk("R5 compare A outranks compare B", pwm_a, 1'b1);
    wr_act(0, 16'h0001);
    step(1, 1, 1, 0, 0);
    chk("R5 none-action period yields to zero", pwm_a, 1'b0);
  endtask

  task automatic t_indep();
    do_reset();
    wr_act(0, 16'h0002);
    wr_act(1, 16'h0008);
    step(1, 1, 0, 0, 0);
    chk("R6 A on zero", pwm_a, 1'b1);
    chk("R6 B untouched by A word", pwm_b, 1'b0);
    step(1, 0, 1, 0, 0);
    chk("R6 B on period", pwm_b, 1'b1);
    chk("R6 A untouched by B word", pwm_a, 1'b1);
  endtask

  task automatic t_force();
    do_reset();
    wr_act(0, 16'h0002);
    wr_act(1, 16'h0002);
    step(1, 1, 0, 0, 0);
    chk("R7 start A high", pwm_a, 1'b1);
    wr_frc(8'h01);
    step(1, 0, 1, 0, 0);
    chk("R8 shadow not yet active", pwm_a, 1'b1);
    step(1, 1, 0, 0, 0);
    chk("R7 override low beats action", pwm_a, 1'b0);
    chk("R7 B free of A override", pwm_b, 1'b1);
    step(1, 1, 0, 0, 0);
    chk("R7 override persists", pwm_a, 1'b0);
    wr_frc(8'h08);
    wr_act(1, 16'h0001);
    step(1, 1, 0, 0, 0);
    chk("R7 A released", pwm_a, 1'b1);
    chk("R7 override high on B", pwm_b, 1'b1);
    wr_frc(8'h03);
    wr_act(0, 16'h0001);
    step(1, 1, 0, 0, 0);
    chk("R7 code 3 means no override", pwm_a, 1'b0);
  endtask

  task automatic t_reload();
    do_reset();
    wr_rld(2'd1);
    wr_frc(8'h02);
    step(1, 1, 0, 0, 0);
    chk("R8 mode 1 ignores zero", pwm_a, 1'b0);
    step(1, 0, 1, 0, 0);
    chk("R8 mode 1 reloads on period", pwm_a, 1'b1);
    wr_rld(2'd2);
    wr_frc(8'h01);
    step(1, 1, 0, 0, 0);
    chk("R8 mode 2 reloads on zero", pwm_a, 1'b0);
    wr_frc(8'h02);
    step(1, 0, 1, 0, 0);
    chk("R8 mode 2 reloads on period", pwm_a, 1'b1);
    wr_rld(2'd3);
    wr_frc(8'h01);
    step(1, 0, 0, 0, 0);
    chk("R8 mode 3 reloads on bare tick", pwm_a, 1'b0);
    wr_frc(8'h02);
    step(0, 1, 1, 0, 0);
    chk("R8 mode 3 waits for tick", pwm_a, 1'b0);
    step(1, 0, 0, 0, 0);
    chk("R8 mode 3 next tick", pwm_a, 1'b1);
  endtask

  task automatic t_polarity();
    do_reset();
    wr_act(0, 16'h001A);
    wr_act(1, 16'h0205);
    step(1, 1, 0, 0, 0);
    chk("R9 normal high at zero", pwm_a, 1'b1);
    chk("R9 inverted low at zero", pwm_b, 1'b0);
    step(1, 0, 0, 1, 0);
    chk("R9 normal low at compare A", pwm_a, 1'b0);
    step(1, 0, 0, 0, 1);
    chk("R9 inverted high at compare B", pwm_b, 1'b1);
    step(1, 0, 1, 0, 0);
    chk("R9 normal high at period", pwm_a, 1'b1);
    chk("R9 inverted low at period", pwm_b, 1'b0);
  endtask

  initial begin
    t_reset();
    t_tick_gate();
    t_codes();
    t_fields();
    t_prio();
    t_indep();
    t_force();
    t_reload();
    t_polarity();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule